// File: doc/BRIEF.md
# Four-Port Mailbox Interrupt Controller

This block raises message-passing interrupts between the four ports of a shared memory. It watches the access strobes of every port: a valid bit, a write enable and an address. The four highest addresses of the memory are treated as mailboxes, one owned by each port. When one port writes the mailbox of another port, the owner's active-low interrupt line goes low. The line returns high once the owner reads its own mailbox.

Each owner's flag is a two-state machine. In `FLAG_IDLE` the line is high. In `FLAG_PEND` the line is low. The transition `IDLE->PEND` is taken on any foreign write to the owner's mailbox. The transition `PEND->IDLE` is taken on an owner read that is not paired with a foreign write in the same cycle. All other cases leave the state where it is. The memory array, the mailbox data and access arbitration are handled elsewhere.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives all four `irq_n` bits high.
- R2: The mailbox owned by port i (i = 0..3) sits at address 2^ADDR_W − 4 + i: every upper bit is one and the two low bits equal i. With ADDR_W = 10 these addresses are 1020..1023.
- R3: A valid write (`acc_valid[p]`=1, `acc_we[p]`=1) by port p to the mailbox of port j, with p ≠ j, drives `irq_n[j]` low at the next rising edge.
- R4: A valid read (`acc_we`=0) by port j of its own mailbox returns `irq_n[j]` high at the next rising edge.
- R5: A port that writes its own mailbox leaves its own flag unchanged.
- R6: If a foreign write and an owner read reach the same mailbox in one cycle, the flag ends up low, so the set wins.
- R7: Accesses to addresses outside the mailbox range, and reads of another port's mailbox, change no flag.
- R8: A flag holds its value in cycles with no set and no clear. Several ports may write the same mailbox at once, and the result is one set.
- R9: An access with `acc_valid` low has no effect, whatever `acc_we` and the address are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 4 | Per-port access strobe |
| acc_we | input | 4 | Per-port write enable (1 = write, 0 = read) |
| acc_addr | input | 4*ADDR_W | Per-port address, port p in bits [p*ADDR_W +: ADDR_W] |
| irq_n | output | 4 | Per-port mailbox interrupt, active low |

## Verification
The bench goes after the cycle in which a foreign write and the owner's read hit the same mailbox. A design that lets the clear win would silently drop a message. It also writes each port's own mailbox and reads other ports' mailboxes; a decoder that ignores the port identity would raise or clear the wrong flags. Addresses just below the mailbox range, and strobes with valid low, expose a design that decodes too few address bits or ignores the valid qualifier. A full sweep of every port against every mailbox catches a swapped index mapping.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
    parameter int ADDR_W = 10,
    parameter int NPORT  = 4,
    parameter int SELF   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NPORT-1:0]  set_req,
    output logic [NPORT-1:0]  clr_req
);
    localparam int IDX_W = $clog2(NPORT);

    logic             in_box;
    logic [IDX_W-1:0] box_idx;

    assign in_box  = acc_valid && (&acc_addr[ADDR_W-1:IDX_W]);
    assign box_idx = acc_addr[IDX_W-1:0];

    for (genvar j = 0; j < NPORT; j++) begin : g_box
        if (j == SELF) begin : g_own
            assign set_req[j] = 1'b0;
            assign clr_req[j] = in_box && !acc_we && (box_idx == IDX_W'(j));
        end else begin : g_other
            assign set_req[j] = in_box && acc_we && (box_idx == IDX_W'(j));
            assign clr_req[j] = 1'b0;
        end
    end

    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst)
        !set_req[SELF]) else $error("self set");                              // R5
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (clr_req != '0) |-> (acc_valid && !acc_we)) else $error("bad clear");    // R7
endmodule

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm
    import mbox_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] set_by_port,
    input  logic             clr,
    output logic             irq_n
);
    flag_state_t state_q, state_d;
    logic        set_any;

    assign set_any = |set_by_port;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_any)         state_d = FLAG_PEND;
            FLAG_PEND: if (clr && !set_any) state_d = FLAG_IDLE;
            default:                        state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        irq_n = (state_q != FLAG_PEND);
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> irq_n) else $error("reset");                                  // R1
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        set_any |=> !irq_n) else $error("set");                               // R3
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_any) |=> irq_n) else $error("clear");                    // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set_any) |=> $stable(irq_n)) else $error("hold");           // R8
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl #(
    parameter int ADDR_W = 10,
    parameter int NPORT  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        acc_valid,
    input  logic [NPORT-1:0]        acc_we,
    input  logic [NPORT*ADDR_W-1:0] acc_addr,
    output logic [NPORT-1:0]        irq_n
);
    logic [NPORT-1:0] set_mat [NPORT];
    logic [NPORT-1:0] clr_mat [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        mbox_port_decode #(.ADDR_W(ADDR_W), .NPORT(NPORT), .SELF(p)) u_dec (
            .clk       (clk),
            .rst       (rst),
            .acc_valid (acc_valid[p]),
            .acc_we    (acc_we[p]),
            .acc_addr  (acc_addr[p*ADDR_W +: ADDR_W]),
            .set_req   (set_mat[p]),
            .clr_req   (clr_mat[p])
        );
    end

    for (genvar j = 0; j < NPORT; j++) begin : g_flag
        logic [NPORT-1:0] set_col;
        always_comb begin
            for (int p = 0; p < NPORT; p++) set_col[p] = set_mat[p][j];
        end

        mbox_flag_fsm #(.NPORT(NPORT)) u_fsm (
            .clk         (clk),
            .rst         (rst),
            .set_by_port (set_col),
            .clr         (clr_mat[j][j]),
            .irq_n       (irq_n[j])
        );

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            ((set_col != '0) && clr_mat[j][j]) |=> !irq_n[j]) else $error("set wins"); // R6
    end
endmodule

// File: tb/mbox_irq_ctrl_test.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_test;
    localparam int W = 10;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   acc_valid = '0;
    logic [N-1:0]   acc_we = '0;
    logic [N*W-1:0] acc_addr = '0;
    logic [N-1:0]   irq_n;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] model = '1;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    bit           done = 0;

    always #2 clk = ~clk;

    mbox_irq_ctrl #(.ADDR_W(W), .NPORT(N)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_addr(acc_addr), .irq_n(irq_n)
    );

    function automatic int mb(int i);
        return (1 << W) - 4 + i;
    endfunction

    // driver: one access cycle for all ports, expected flags pushed to scoreboard
    task automatic cyc(input logic [N-1:0] v, input logic [N-1:0] we,
                       input int a0, input int a1, input int a2, input int a3,
                       input string tag);
        int a[N];
        logic [N-1:0] nx;
        a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
        @(negedge clk);
        acc_valid = v;
        acc_we    = we;
        for (int p = 0; p < N; p++) acc_addr[p*W +: W] = W'(a[p]);
        nx = model;
        for (int j = 0; j < N; j++) begin
            logic s, c;
            s = 1'b0;
            for (int p = 0; p < N; p++)
                if (p != j && v[p] && we[p] && a[p] == mb(j)) s = 1'b1;
            c = v[j] && !we[j] && a[j] == mb(j);
            if (s) nx[j] = 1'b0;
            else if (c) nx[j] = 1'b1;
        end
        model = nx;
        exp_q.push_back(nx);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        cyc(4'b0000, 4'b0000, 0, 0, 0, 0, tag);
    endtask

    // monitor: compare one result per edge, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (irq_n !== e) begin
                errors++;
                $display("FAIL %s: irq_n=%b expected %b", t, irq_n, e);
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (irq_n !== 4'hF) begin
            errors++;
            $display("FAIL R1: irq_n=%b expected 1111", irq_n);
        end

        // R3 / R2: port1 writes mailbox of port0
        cyc(4'b0010, 4'b0010, 0, mb(0), 0, 0, "R3 foreign write sets");
        idle("R8 hold after set");
        // R7: port2 reads mailbox 0 (not owner), port3 writes just below range
        cyc(4'b1100, 4'b1000, 0, 0, mb(0), mb(0) - 1, "R7 non-owner read / out of range");
        // R4: owner reads
        cyc(4'b0001, 4'b0000, mb(0), 0, 0, 0, "R4 owner read clears");
        // R5: self write
        cyc(4'b0100, 4'b0100, 0, 0, mb(2), 0, "R5 self write ignored");
        // R9: valid low with mailbox write
        cyc(4'b0000, 4'b1111, mb(1), mb(2), mb(3), mb(0), "R9 valid low ignored");
        // R6: set and clear same cycle
        cyc(4'b0001, 4'b0001, mb(3), 0, 0, 0, "R3 set port3");
        cyc(4'b1010, 4'b0010, 0, mb(3), 0, mb(3), "R6 set wins over clear");
        cyc(4'b1000, 4'b0000, 0, 0, 0, mb(3), "R4 clear after collision");
        // R8: multiple writers to one mailbox
        cyc(4'b1101, 4'b1101, mb(1), 0, mb(1), mb(1), "R8 multiple writers");
        cyc(4'b0010, 4'b0000, 0, mb(1), 0, 0, "R4 clear port1");
        // R2/R3: every port writes next port's mailbox
        cyc(4'b1111, 4'b1111, mb(1), mb(2), mb(3), mb(0), "R2 ring writes");
        cyc(4'b1111, 4'b0000, mb(0), mb(1), mb(2), mb(3), "R4 all owners read");
        // R7: address with low bits matching but upper bit clear
        cyc(4'b0001, 4'b0001, mb(1) - 512, 0, 0, 0, "R7 partial decode");
        // sweep: every port writes every mailbox, then owner reads
        for (int p = 0; p < N; p++) begin
            for (int j = 0; j < N; j++) begin
                int a[N];
                for (int k = 0; k < N; k++) a[k] = 0;
                a[p] = mb(j);
                cyc(4'(1 << p), 4'(1 << p), a[0], a[1], a[2], a[3], "R2 sweep write");
                for (int k = 0; k < N; k++) a[k] = 0;
                a[j] = mb(j);
                cyc(4'(1 << j), 4'b0000, a[0], a[1], a[2], a[3], "R4 sweep read");
            end
        end
        // R1: reset while flags pending
        cyc(4'b0001, 4'b0001, mb(2), 0, 0, 0, "R3 set before reset");
        @(negedge clk);
        rst = 1'b1;
        acc_valid = '0;
        @(negedge clk);
        rst = 1'b0;
        model = '1;
        checks++;
        if (irq_n !== 4'hF) begin
            errors++;
            $display("FAIL R1: irq_n=%b expected 1111 after reset", irq_n);
        end
        idle("R1 idle after reset");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule